// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block puts one packet on a low-speed USB pair. A caller asks for a packet by pulsing `start` with a byte count from 2 to 12 inclusive. The count covers a sync byte that the block makes by itself. The block then takes the remaining payload bytes one at a time from a byte source through a request strobe. It sends every byte least significant bit first. The line code is NRZI, and a stuff bit is added after every run of six ones. The packet ends with an end-of-packet sequence, after which the block releases the bus.

The block runs from a clock with a fixed number of clocks per bit time (8 by default, for 1.5 Mbit/s from 12 MHz). It applies no fractional correction, because the transmit rate tolerance is loose. A packet longer than two bytes counts as a data packet. When a data packet finishes, the block copies the pending device address into the active address register. A two-byte handshake packet (sync plus PID) leaves the active address unchanged.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset, busy=0, tx_en=0, byte_req=0 and dev_addr=0, and the pins show idle J (dp_out=0, dm_out=1).
- R2: If start=1 is seen while the block is idle and byte_cnt is in the range 2..12, busy and tx_en go to 1 on the next cycle. The block then drives J for one bit time (CLKS_PER_BIT clocks) before the first sync bit.
- R3: After the leading J, the block sends the sync byte 0x80 and then byte_cnt-1 payload bytes. Each byte goes LSB first and each bit lasts CLKS_PER_BIT clocks. Under NRZI, a 0 bit toggles the line between J (dp=0, dm=1) and K (dp=1, dm=0), and a 1 bit keeps the level.
- R4: After six consecutive 1 bits the block inserts one toggle. This also happens when the sixth 1 is the last payload bit. Any 0, including a stuffed toggle, clears the run count, so the run count never exceeds six.
- R5: byte_req pulses for one cycle at each boundary where bit 7 of a byte is sent and more bytes remain. byte_data is taken in that same cycle, so there are exactly byte_cnt-1 pulses per packet, and none while idle.
- R6: The end-of-packet sequence is SE0 (dp=dm=0) for two bit times, then J for one bit time. After that, tx_en and busy drop together, and the line at release is J.
- R7: When a packet with byte_cnt>2 finishes, dev_addr takes new_addr on the same edge at which busy drops. dev_addr does not change while busy is 1.
- R8: When a packet with byte_cnt=2 finishes, dev_addr keeps its previous value.
- R9: A start seen while busy has no effect on the packet in flight. A start with byte_cnt outside 2..12 leaves the block idle.
- R10: dp_out and dm_out are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-engine clock (CLKS_PER_BIT clocks per bit) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Packet request, taken only while idle |
| byte_cnt | input | 4 | Bytes in packet including sync (2..12) |
| byte_data | input | 8 | Next payload byte, valid in the byte_req cycle |
| byte_req | output | 1 | One-cycle pull of the next payload byte |
| new_addr | input | 7 | Pending device address |
| dev_addr | output | 7 | Active device address |
| tx_en | output | 1 | Line driver enable |
| dp_out | output | 1 | D+ level driven |
| dm_out | output | 1 | D- level driven |
| busy | output | 1 | High from accepted start until drivers release |

## Verification
The hardest case to reach is a stuff toggle that falls after the very last payload bit, just ahead of SE0. If that toggle is dropped or misplaced, the end-of-packet sequence shifts by one bit time. The stimulus reaches this case with payloads ending in 0xFC, whose six trailing ones complete a run exactly at the packet's end. One of these is a handshake and one is a data packet. A second hard case is a start request that arrives mid-packet. The stimulus raises start during the fourth symbol of a packet with a different count and then checks that the waveform and the request total stay unchanged.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_DATA,
    ST_SE0,
    ST_EOPJ
  } tx_state_t;

  localparam logic [7:0] SYNC_PATTERN = 8'h80;

  function automatic logic count_ok(input int c, input int lo, input int hi);
    return (c >= lo) && (c <= hi);
  endfunction

  // NRZI: a one holds the level, a zero flips it
  function automatic logic nrzi_next(input logic level, input logic b);
    return b ? level : ~level;
  endfunction
endpackage

// File: rtl/usb_ls_tx_bitclk.sv
module usb_ls_tx_bitclk #(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PH_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLKS_PER_BIT - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ph_q <= '0;
    else if (!run)           ph_q <= '0;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                     ph_q <= ph_q + PH_W'(1);
  end

  assign tick = run && (ph_q == PH_LAST);
endmodule

// File: rtl/usb_ls_tx_nrzi.sv
module usb_ls_tx_nrzi
  import usb_ls_tx_pkg::*;
#(
  parameter int RUN_LIMIT = 6,
  localparam int RW = $clog2(RUN_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          emit_bit,
  input  logic          bit_val,
  input  logic          emit_stuff,
  output logic          level,
  output logic [RW-1:0] run_len,
  output logic          stuff_due
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= 1'b1;
      run_len <= '0;
    end else if (init) begin
      level   <= 1'b1;
      run_len <= '0;
    end else if (emit_stuff) begin
      level   <= ~level;
      run_len <= '0;
    end else if (emit_bit) begin
      level   <= nrzi_next(level, bit_val);
      run_len <= bit_val ? run_len + RW'(1) : '0;
    end
  end

  assign stuff_due = (run_len == RW'(RUN_LIMIT));
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 8,
  parameter int MIN_BYTES    = 2,
  parameter int MAX_BYTES    = 12,
  parameter int CNT_W        = 4,
  parameter int ADDR_W       = 7,
  parameter int RUN_LIMIT    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [7:0]        byte_data,
  output logic              byte_req,
  input  logic [ADDR_W-1:0] new_addr,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              tx_en,
  output logic              dp_out,
  output logic              dm_out,
  output logic              busy
);
  localparam int RW = $clog2(RUN_LIMIT + 1);

  tx_state_t        state_q;
  logic [7:0]       shreg_q;
  logic [2:0]       bidx_q;
  logic [CNT_W-1:0] left_q;
  logic             last_q;
  logic             data_pkt_q;
  logic             eop_half_q;

  // named internal events
  logic          tick;
  logic          accept;
  logic          bit_evt;
  logic          stuff_evt;
  logic          end_evt;
  logic          byte_end;
  logic          pkt_done;
  logic          level;
  logic          stuff_due;
  logic [RW-1:0] run_len;

  assign accept = (state_q == ST_IDLE) && start &&
                  count_ok(int'(byte_cnt), MIN_BYTES, MAX_BYTES);

  usb_ls_tx_bitclk #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_bitclk (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state_q != ST_IDLE),
    .tick (tick)
  );

  assign bit_evt   = tick && ((state_q == ST_LEAD) ||
                              ((state_q == ST_DATA) && !stuff_due && !last_q));
  assign stuff_evt = tick && (state_q == ST_DATA) && stuff_due;
  assign end_evt   = tick && (state_q == ST_DATA) && !stuff_due && last_q;
  assign byte_end  = bit_evt && (bidx_q == 3'd7);
  assign byte_req  = byte_end && (left_q != '0);
  assign pkt_done  = tick && (state_q == ST_EOPJ);

  usb_ls_tx_nrzi #(.RUN_LIMIT(RUN_LIMIT)) u_nrzi (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (accept),
    .emit_bit  (bit_evt),
    .bit_val   (shreg_q[0]),
    .emit_stuff(stuff_evt),
    .level     (level),
    .run_len   (run_len),
    .stuff_due (stuff_due)
  );

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      eop_half_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) state_q <= ST_LEAD;
        ST_LEAD: if (tick)   state_q <= ST_DATA;
        ST_DATA: if (end_evt) begin
          state_q    <= ST_SE0;
          eop_half_q <= 1'b0;
        end
        ST_SE0: if (tick) begin
          if (eop_half_q) state_q <= ST_EOPJ;
          eop_half_q <= 1'b1;
        end
        ST_EOPJ: if (tick) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // byte shifter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q    <= '0;
      bidx_q     <= '0;
      left_q     <= '0;
      last_q     <= 1'b0;
      data_pkt_q <= 1'b0;
    end else if (accept) begin
      shreg_q    <= SYNC_PATTERN;
      bidx_q     <= '0;
      left_q     <= byte_cnt - CNT_W'(1);
      last_q     <= 1'b0;
      data_pkt_q <= int'(byte_cnt) > MIN_BYTES;
    end else if (bit_evt) begin
      bidx_q <= bidx_q + 3'd1;
      if (byte_end) begin
        if (left_q != '0) begin
          shreg_q <= byte_data;
          left_q  <= left_q - CNT_W'(1);
        end else begin
          shreg_q <= '0;
          last_q  <= 1'b1;
        end
      end else begin
        shreg_q <= {1'b0, shreg_q[7:1]};
      end
    end
  end

  // deferred address update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      dev_addr <= '0;
    else if (pkt_done && data_pkt_q) dev_addr <= new_addr;
  end

  logic se0_drv;
  logic j_drv;
  assign se0_drv = (state_q == ST_SE0);
  assign j_drv   = (state_q == ST_IDLE) || (state_q == ST_LEAD) || (state_q == ST_EOPJ);

  assign tx_en  = (state_q != ST_IDLE);
  assign busy   = (state_q != ST_IDLE);
  assign dm_out = !se0_drv && (j_drv || level);
  assign dp_out = !se0_drv && !j_drv && !level;
endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk #(
  parameter int RUN_LIMIT = 6,
  parameter int MIN_BYTES = 2,
  parameter int MAX_BYTES = 12,
  parameter int RW        = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [3:0]    byte_cnt,
  input logic          byte_req,
  input logic [6:0]    dev_addr,
  input logic          tx_en,
  input logic          dp_out,
  input logic          dm_out,
  input logic          busy,
  input logic [RW-1:0] run_len
);
  // R10
  no_both_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp_out && dm_out));

  // R4
  run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_len) <= RUN_LIMIT);

  // R5
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |-> busy);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(dev_addr));

  // R6
  release_from_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> ($past(dm_out) && !$past(dp_out)));

  // R9
  bad_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && ((int'(byte_cnt) < MIN_BYTES) || (int'(byte_cnt) > MAX_BYTES)))
      |=> !busy);
endmodule

bind usb_ls_tx usb_ls_tx_chk #(.RUN_LIMIT(6), .MIN_BYTES(2), .MAX_BYTES(12), .RW(3)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .byte_cnt(byte_cnt),
  .byte_req(byte_req),
  .dev_addr(dev_addr),
  .tx_en   (tx_en),
  .dp_out  (dp_out),
  .dm_out  (dm_out),
  .busy    (busy),
  .run_len (run_len)
);

// File: tb/tb_usb_ls_tx.sv
module tb_usb_ls_tx;
  localparam int NVEC = 6;
  localparam int MAXSYM = 160;
  // per vector: byte count, payload fill, payload step, pending address, poke start mid-packet
  localparam logic [3:0] V_CNT  [NVEC] = '{4'd2, 4'd3, 4'd2, 4'd12, 4'd4, 4'd7};
  localparam logic [7:0] V_FILL [NVEC] = '{8'hD2, 8'hFF, 8'hFC, 8'h00, 8'hFC, 8'hA5};
  localparam logic [7:0] V_STEP [NVEC] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h5A};
  localparam logic [6:0] V_ADDR [NVEC] = '{7'h11, 7'h23, 7'h31, 7'h05, 7'h40, 7'h2A};
  localparam logic       V_POKE [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] byte_cnt = 4'd0;
  logic [7:0] byte_data;
  logic       byte_req;
  logic [6:0] new_addr = 7'd0;
  logic [6:0] dev_addr;
  logic       tx_en, dp_out, dm_out, busy;

  logic [7:0] pay [16];
  logic [3:0] idx;
  logic       clr = 1'b0;
  int checks = 0;
  int fails = 0;
  logic [6:0] exp_addr = 7'd0;

  logic [1:0] sym [MAXSYM];
  int         tag [MAXSYM];
  int         nsym;

  always #5 clk = ~clk;

  usb_ls_tx dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
    .byte_data(byte_data), .byte_req(byte_req), .new_addr(new_addr),
    .dev_addr(dev_addr), .tx_en(tx_en), .dp_out(dp_out), .dm_out(dm_out),
    .busy(busy)
  );

  assign byte_data = pay[idx];

  always @(posedge clk) begin
    if (clr) idx <= 4'd0;
    else if (byte_req) idx <= idx + 4'd1;
  end

  function automatic string tname(input int t);
    case (t)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // symbol code {dp,dm}: J=1, K=2, SE0=0
  task automatic build(input int cnt);
    logic lvl;
    int ones;
    logic [7:0] b;
    lvl = 1'b1; ones = 0; nsym = 0;
    sym[nsym] = 2'b01; tag[nsym] = 0; nsym++;
    for (int i = 0; i < cnt; i++) begin
      b = (i == 0) ? 8'h80 : pay[i-1];
      for (int k = 0; k < 8; k++) begin
        if (!b[k]) begin lvl = ~lvl; ones = 0; end
        else ones++;
        sym[nsym] = lvl ? 2'b01 : 2'b10; tag[nsym] = 1; nsym++;
        if (ones == 6) begin
          lvl = ~lvl; ones = 0;
          sym[nsym] = lvl ? 2'b01 : 2'b10; tag[nsym] = 2; nsym++;
        end
      end
    end
    sym[nsym] = 2'b00; tag[nsym] = 3; nsym++;
    sym[nsym] = 2'b00; tag[nsym] = 3; nsym++;
    sym[nsym] = 2'b01; tag[nsym] = 3; nsym++;
  endtask

  task automatic run_pkt(input int cnt, input logic [7:0] fill, input logic [7:0] step,
                         input logic [6:0] addr, input logic poke);
    for (int i = 0; i < 16; i++) pay[i] = fill + step * 8'(i);
    build(cnt);
    @(negedge clk);
    start = 1'b1; byte_cnt = 4'(cnt); new_addr = addr; clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; clr = 1'b0;
    for (int k = 0; k < nsym; k++) begin
      if (k == 0) repeat (4) @(posedge clk);
      else repeat (8) @(posedge clk);
      @(negedge clk);
      if (k == 0) begin
        chk("R2 busy", int'(busy), 1);
        chk("R2 tx_en", int'(tx_en), 1);
      end
      chk(tname(tag[k]), int'({dp_out, dm_out}), int'(sym[k]));
      chk("R10 pins", int'(dp_out && dm_out), 0);
      if (poke && k == 3) begin start = 1'b1; byte_cnt = 4'd5; end
      if (poke && k == 4) begin start = 1'b0; byte_cnt = 4'(cnt); end
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    if (cnt > 2) begin
      exp_addr = addr;
      chk("R7 addr", int'(dev_addr), int'(exp_addr));
    end else begin
      chk("R8 addr", int'(dev_addr), int'(exp_addr));
    end
    chk("R6 tx_en", int'(tx_en), 0);
    chk("R6 busy", int'(busy), 0);
    chk("R6 idle J", int'({dp_out, dm_out}), 1);
    chk("R5 requests", int'(idx), cnt - 1);
    if (poke) chk("R9 busy start", int'(idx), cnt - 1);
  endtask

  task automatic bad_start(input int cnt);
    @(negedge clk);
    start = 1'b1; byte_cnt = 4'(cnt);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R9 bad count busy", int'(busy), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 bad count tx_en", int'(tx_en), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk("R1 busy", int'(busy), 0);
    chk("R1 tx_en", int'(tx_en), 0);
    chk("R1 req", int'(byte_req), 0);
    chk("R1 addr", int'(dev_addr), 0);
    chk("R1 pins", int'({dp_out, dm_out}), 1);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    for (int v = 0; v < NVEC; v++)
      run_pkt(int'(V_CNT[v]), V_FILL[v], V_STEP[v], V_ADDR[v], V_POKE[v]);
    bad_start(1);
    bad_start(13);
    bad_start(0);
    chk("R8 addr after bad", int'(dev_addr), int'(exp_addr));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule